// File: doc/BRIEF.md
# Isochronous Transmit Interrupt Event Register

This block holds one event bit for each of eight isochronous transmit contexts. A context pulses or raises its completion request when a final output descriptor finishes with interrupts enabled. The block catches the rising edge of that request and keeps the bit set until software clears it. Software reaches the bits over a small 32-bit register bus. One address sets bits and another clears them, and both addresses map onto the same storage.

A read of the set address returns the raw event bits. A read of the clear address returns the events gated by an 8-bit mask supplied by a companion mask register. The block reports one summary request to the chip-level interrupt event register. The summary is high whenever any unmasked event is pending, so software can then read this block to see which contexts caused it. Read data comes back one cycle after the read strobe.

Top module: `isotx_evt_reg`

## Requirements
- R1: After reset all event bits are 0, `bus_rdata` is 0 and `summary_irq` is 0.
- R2: A 0-to-1 transition on `irq_req[i]` sets event bit i at the next clock edge. A request held high sets the bit only once, so after a clear the bit stays 0 until a new rising edge.
- R3: Writing at the set address (0x90) sets every event bit whose `bus_wdata` bit (7..0) is 1. Bits written as 0 keep their value.
- R4: Writing at the clear address (0x94) clears every event bit whose `bus_wdata` bit is 1. Bits written as 0 keep their value. Nothing else clears a bit once reset is over.
- R5: A read at 0x90 returns the event bits in `bus_rdata[7:0]` on the cycle after `bus_rd`. The value is the one held before that clock edge.
- R6: A read at 0x94 returns the event bits ANDed with `ctx_mask` in `bus_rdata[7:0]`, with the same timing as R5.
- R7: `bus_rdata[31:8]` always reads 0, and `bus_wdata[31:8]` has no effect.
- R8: `summary_irq` is 1 exactly when some event bit is 1 and its `ctx_mask` bit is 1. A masked event stays stored.
- R9: When a rising request edge and a clear write hit the same bit in the same cycle, the bit ends at 1.
- R10: Writes to any address other than 0x90 and 0x94 change no event bit, and reads at such addresses return 0.
- R11: `bus_rdata` is 0 on every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_req | input | 8 | Per-context completion requests, synchronous to `clk` |
| ctx_mask | input | 8 | Per-context mask from the mask register |
| summary_irq | output | 1 | Summary request to the chip-level event register |

## Verification
The bench drives all 256 set-write patterns. After each one it reads both views under a mask derived from the pattern, which tells masked gating apart from raw storage and shows how the summary follows it. It also drives all 256 clear-write patterns starting from all ones, which separates the bits that are cleared from the bits that are kept. Single-bit request edges, held levels, and edges that coincide with a clear separate true edge capture from level capture and show the set-over-clear priority. Accesses with high write data bits and to unmapped addresses show that those bits and addresses are ignored.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_pkg::*;
#(
  parameter int unsigned            ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]      SET_ADDR = 8'h90,
  parameter logic [ADDR_W-1:0]      CLR_ADDR = 8'h94
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind
);
  always_comb begin
    if (addr == SET_ADDR)      kind = ACC_SET;
    else if (addr == CLR_ADDR) kind = ACC_CLR;
    else                       kind = ACC_NONE;
  end
endmodule

// File: rtl/evt_edge_detect.sv
module evt_edge_detect #(
  parameter int unsigned N_CTX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CTX-1:0] req,
  output logic [N_CTX-1:0] rise
);
  logic [N_CTX-1:0] req_q;
  logic [N_CTX-1:0] req_d;

  always_comb begin
    req_d = req;
    rise  = req & ~req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/evt_store.sv
module evt_store #(
  parameter int unsigned N_CTX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CTX-1:0] rise,
  input  logic [N_CTX-1:0] set_hit,
  input  logic [N_CTX-1:0] clr_hit,
  output logic [N_CTX-1:0] evt
);
  for (genvar i = 0; i < N_CTX; i++) begin : g_bit
    logic bit_q;
    logic bit_d;
    logic bit_en;

    always_comb begin
      bit_en = rise[i] | set_hit[i] | clr_hit[i];
      bit_d  = rise[i] | set_hit[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign evt[i] = bit_q;
  end
endmodule

// File: rtl/evt_read_port.sv
module evt_read_port
  import evt_pkg::*;
#(
  parameter int unsigned N_CTX  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  acc_kind_e         kind,
  input  logic [N_CTX-1:0]  evt,
  input  logic [N_CTX-1:0]  mask,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - N_CTX;

  logic [N_CTX-1:0]  view;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    unique case (kind)
      ACC_SET: view = evt;
      ACC_CLR: view = evt & mask;
      default: view = '0;
    endcase
    rdata_d = rd ? {{PAD_W{1'b0}}, view} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/isotx_evt_reg.sv
module isotx_evt_reg
  import evt_pkg::*;
#(
  parameter int unsigned       N_CTX    = 8,
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SET_ADDR = 8'h90,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h94
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_CTX-1:0]  irq_req,
  input  logic [N_CTX-1:0]  ctx_mask,
  output logic              summary_irq
);
  logic             rst_sync_n;
  acc_kind_e        kind;
  logic [N_CTX-1:0] rise;
  logic [N_CTX-1:0] set_hit;
  logic [N_CTX-1:0] clr_hit;
  logic [N_CTX-1:0] evt_q;

  evt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  evt_addr_decode #(
    .ADDR_W   (ADDR_W),
    .SET_ADDR (SET_ADDR),
    .CLR_ADDR (CLR_ADDR)
  ) u_dec (
    .addr (bus_addr),
    .kind (kind)
  );

  evt_edge_detect #(.N_CTX(N_CTX)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (irq_req),
    .rise  (rise)
  );

  always_comb begin
    set_hit = (bus_wr && kind == ACC_SET) ? bus_wdata[N_CTX-1:0] : '0;
    clr_hit = (bus_wr && kind == ACC_CLR) ? bus_wdata[N_CTX-1:0] : '0;
  end

  evt_store #(.N_CTX(N_CTX)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rise    (rise),
    .set_hit (set_hit),
    .clr_hit (clr_hit),
    .evt     (evt_q)
  );

  evt_read_port #(.N_CTX(N_CTX), .DATA_W(DATA_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rd    (bus_rd),
    .kind  (kind),
    .evt   (evt_q),
    .mask  (ctx_mask),
    .rdata (bus_rdata)
  );

  assign summary_irq = |(evt_q & ctx_mask);
endmodule

// File: rtl/evt_reg_chk.sv
module evt_reg_chk #(
  parameter int unsigned       N_CTX    = 8,
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SET_ADDR = 8'h90,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h94
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_CTX-1:0]  irq_req,
  input logic              summary_irq,
  input logic [N_CTX-1:0]  evt
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:N_CTX] == '0); // R7

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0); // R11

  AST_RAW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == SET_ADDR) |=> bus_rdata[N_CTX-1:0] == $past(evt)); // R5

  AST_MASKED_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CLR_ADDR) |=> (bus_rdata[N_CTX-1:0] != '0) == $past(summary_irq)); // R8

  for (genvar i = 0; i < N_CTX; i++) begin : g_bit_chk
    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req[i]) |=> evt[i]); // R2

    AST_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == SET_ADDR && bus_wdata[i]) |=> evt[i]); // R3

    AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(evt[i]) |-> $past(bus_wr && bus_addr == CLR_ADDR && bus_wdata[i])); // R4
  end
endmodule

bind isotx_evt_reg evt_reg_chk #(
  .N_CTX    (N_CTX),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .SET_ADDR (SET_ADDR),
  .CLR_ADDR (CLR_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .irq_req     (irq_req),
  .summary_irq (summary_irq),
  .evt         (evt_q)
);

// File: tb/isotx_evt_reg_tb.sv
module isotx_evt_reg_tb;
  localparam logic [7:0] A_SET = 8'h90;
  localparam logic [7:0] A_CLR = 8'h94;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_req = '0;
  logic [7:0]  ctx_mask = '0;
  logic        summary_irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [7:0] exp_evt = '0;

  always #2 clk = ~clk;

  isotx_evt_reg u_dut (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_wdata (bus_wdata), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
    .irq_req (irq_req), .ctx_mask (ctx_mask), .summary_irq (summary_irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    if (a == A_SET) exp_evt = exp_evt | d[7:0];
    else if (a == A_CLR) exp_evt = exp_evt & ~d[7:0];
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  m;
    idle(3);
    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 summary", {31'b0, summary_irq}, 32'h0);
    rst_n = 1'b1;
    idle(4);
    ctx_mask = 8'hFF;
    rd(A_SET, d); chk("R1 events", d, 32'h0);

    // R3, R5, R6, R8, R7: sweep every set pattern
    for (int v = 0; v < 256; v++) begin
      wr(A_CLR, 32'hFF);
      wr(A_SET, {24'hA5A5A5, v[7:0]});
      m = v[7:0] ^ 8'h5A ^ {v[3:0], v[7:4]};
      ctx_mask = m;
      rd(A_SET, d); chk("R3/R5/R7 raw view", d, {24'h0, exp_evt});
      rd(A_CLR, d); chk("R6 masked view", d, {24'h0, exp_evt & m});
      chk("R8 summary", {31'b0, summary_irq}, {31'b0, |(exp_evt & m)});
    end

    // R3: writing zeros at set keeps bits
    ctx_mask = 8'hFF;
    wr(A_CLR, 32'hFF); wr(A_SET, 32'h0000_0081); wr(A_SET, 32'h0);
    rd(A_SET, d); chk("R3 zero write", d, 32'h81);

    // R4: sweep every clear pattern from all ones
    for (int v = 0; v < 256; v++) begin
      wr(A_SET, 32'hFF);
      wr(A_CLR, {24'hFFFFFF, v[7:0]});
      rd(A_SET, d); chk("R4 clear pattern", d, {24'h0, ~v[7:0]});
    end

    // R8: masked event stays stored, no summary
    wr(A_CLR, 32'hFF); wr(A_SET, 32'h10);
    ctx_mask = 8'hEF; idle(1);
    chk("R8 masked no summary", {31'b0, summary_irq}, 32'h0);
    ctx_mask = 8'h10; idle(1);
    chk("R8 unmasked summary", {31'b0, summary_irq}, 32'h1);
    ctx_mask = 8'hFF;

    // R2: rising edges per context, held level
    for (int b = 0; b < 8; b++) begin
      wr(A_CLR, 32'hFF);
      irq_req[b] = 1'b1; idle(1);
      exp_evt[b] = 1'b1;
      rd(A_SET, d); chk("R2 edge capture", d, {24'h0, 8'h1 << b});
      wr(A_CLR, 32'h1 << b); idle(3);
      rd(A_SET, d); chk("R2 held level ignored", d, 32'h0);
      irq_req[b] = 1'b0; idle(1);
      rd(A_SET, d); chk("R2 falling edge ignored", d, 32'h0);
    end

    // R9: edge and clear on the same bit in one cycle
    wr(A_SET, 32'h08);
    bus_addr = A_CLR; bus_wdata = 32'h08; bus_wr = 1'b1; irq_req[3] = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; irq_req[3] = 1'b0;
    rd(A_SET, d); chk("R9 set wins", d, 32'h08);
    exp_evt = 8'h08;

    // R10: unmapped addresses
    wr(8'h98, 32'hFF); wr(8'h91, 32'hFF);
    rd(A_SET, d); chk("R10 unmapped write", d, 32'h08);
    wr(A_SET, 32'hFF);
    rd(8'h8C, d); chk("R10 unmapped read", d, 32'h0);

    // R11: idle cycle after a read
    rd(A_SET, d); chk("R11 read", d, 32'hFF);
    idle(1);
    chk("R11 idle rdata", bus_rdata, 32'h0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule